// File: doc/BRIEF.md
# Transmit Frame Descriptor Gather Engine

This block turns one transmit frame descriptor into a burst of read requests for a downstream data mover. Each descriptor is a 128-byte record. It lists up to twenty scattered host buffers that together make one outgoing frame. The engine keeps a small local copy of descriptors for each queue and one ring base register per queue. When started with a queue number and a ring slot number, it reports the descriptor's host address. It then reads the active-entry count and validates the whole descriptor before any traffic leaves the block.

Each buffer entry is packed into six bytes: a 32-bit low address, then a halfword whose low nibble holds address bits 35:32 and whose upper twelve bits hold the buffer length. If the count, a single length or the frame total is out of range, the engine raises an error and issues nothing. Otherwise it emits one (36-bit address, length) request per accepted valid/ready handshake, in entry order, and pulses done after the last one.

The local store holds `LOCAL_SLOTS` descriptors per queue (a power of two). It is addressed by word as {queue, low bits of slot, word}, and each word is little-endian (byte 0 in bits 7:0).

Top module: `tfd_gather_engine`

## Requirements
- R1: After reset, busy, reqValid, done and err are all low, and every ring base register reads as zero.
- R2: From the cycle after a start is accepted until the walk ends, descAddr equals base × 256 + slot × 128 in 36 bits. Here base is the 28-bit ring base of the chosen queue and slot is the full 8-bit index (0..255). The descriptor is read from the local copy at {queue, slot mod LOCAL_SLOTS}.
- R3: The active count is bits 4:0 of descriptor byte 3. Bits 7:5 of that byte, bytes 0..2 and the bytes after the last entry are ignored. Entry i begins at byte 4+6i: four bytes of low address (least significant first), then a halfword whose bits 3:0 are address bits 35:32 and bits 15:4 are the length.
- R4: For a valid descriptor with count N, exactly N requests are issued for entries 0..N−1 in that order, with one request retiring per cycle in which reqValid and reqReady are both high. reqAddr is {high nibble, low address} and reqLen is the entry length.
- R5: While reqValid is high and reqReady is low, reqValid stays high and reqAddr and reqLen do not change.
- R6: A count of 0 or of more than 20 sets err and issues no request.
- R7: An active entry whose length exceeds 4092 bytes sets err and issues no request. A length of exactly 4092 is accepted.
- R8: A sum of active lengths above 8192 bytes sets err and issues no request. A sum of exactly 8192 is accepted.
- R9: done is a one-cycle pulse that ends every walk, whether it completes or fails. err is valid in the done cycle and keeps its value until the next accepted start.
- R10: A start strobe that arrives while busy is high is ignored. The walk in progress, its requests and descAddr are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWe | input | 1 | Write strobe for a ring base register |
| baseQueue | input | QUEUE_W | Queue whose ring base is written |
| baseAddrHi | input | 28 | Ring base, host address bits 35:8 |
| memWe | input | 1 | Write strobe for the local descriptor store |
| memAddr | input | MEM_AW | Word address {queue, local slot, word} |
| memData | input | 32 | Little-endian descriptor word |
| start | input | 1 | Start strobe, taken only while idle |
| startQueue | input | QUEUE_W | Queue of the descriptor to walk |
| startSlot | input | 8 | Ring slot of the descriptor to walk |
| busy | output | 1 | A walk is in progress |
| descAddr | output | 36 | Host address of the current descriptor |
| reqValid | output | 1 | Read request valid |
| reqReady | input | 1 | Mover accepts the request |
| reqAddr | output | 36 | Buffer host address |
| reqLen | output | 12 | Buffer length in bytes |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Last walk found a malformed descriptor |

## Verification
The bench sweeps the count byte across every legal and illegal value, with junk in the reserved bits. An off-by-one in the count bound would issue twenty-one requests or reject twenty, and a missing mask would reject every descriptor. It places lengths and sums right on the 4092 and 8192 limits, where a strict-versus-inclusive slip either rejects a legal frame or leaks requests from an illegal one. The odd entries straddle word boundaries, so a wrong unpack shows up as scrambled addresses. Stalled handshakes and a start arriving mid-walk show whether the engine skips or repeats entries or restarts on a different descriptor.

// File: rtl/tfd_gather_pkg.sv
package tfd_gather_pkg;
  localparam int unsigned PHYS_ADDR_W = 36;
  localparam int unsigned TB_LEN_W    = 12;
  localparam int unsigned HI_NIB_W    = PHYS_ADDR_W - 32;
  localparam int unsigned DESC_BYTES  = 128;
  localparam int unsigned DESC_WORDS  = DESC_BYTES / 4;
  localparam int unsigned WORD_IDX_W  = $clog2(DESC_WORDS);
  localparam int unsigned RING_BASE_W = 28;
  localparam int unsigned BASE_SHIFT  = PHYS_ADDR_W - RING_BASE_W;
  localparam int unsigned SLOT_SHIFT  = $clog2(DESC_BYTES);
  localparam int unsigned RING_SLOT_W = 8;
  localparam int unsigned COUNT_W     = 5;
  localparam int unsigned COUNT_LSB   = 24;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_SUM   = 2'd2,
    ST_ISSUE = 2'd3
  } walkState_t;

  typedef struct packed {
    logic latchSel;   // capture queue/slot of a new walk
    logic loadCount;  // capture the active count
    logic clrWalk;    // zero entry index and length sum
    logic stepWalk;   // advance to next entry
    logic addLen;     // fold current entry length into sum
  } walkCtl_t;
endpackage

// File: rtl/tfd_entry_unpack.sv
module tfd_entry_unpack
  import tfd_gather_pkg::*;
(
  input  logic                   oddEntry,
  input  logic [31:0]            wordA,
  input  logic [31:0]            wordB,
  output logic [PHYS_ADDR_W-1:0] entryAddr,
  output logic [TB_LEN_W-1:0]    entryLen
);
  logic [31:0] lowAddr;
  logic [15:0] packedHw;

  always_comb begin
    if (oddEntry) begin
      // odd entries start halfway into a word
      lowAddr  = {wordB[15:0], wordA[31:16]};
      packedHw = wordB[31:16];
    end else begin
      lowAddr  = wordA;
      packedHw = wordB[15:0];
    end
    entryAddr = {packedHw[HI_NIB_W-1:0], lowAddr};
    entryLen  = packedHw[15 -: TB_LEN_W];
  end
endmodule

// File: rtl/tfd_gather_dpath.sv
module tfd_gather_dpath
  import tfd_gather_pkg::*;
#(
  parameter int unsigned NUM_QUEUES  = 2,
  parameter int unsigned LOCAL_SLOTS = 4,
  parameter int unsigned MAX_TBS     = 20,
  localparam int unsigned QUEUE_W   = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int unsigned LSLOT_W   = (LOCAL_SLOTS > 1) ? $clog2(LOCAL_SLOTS) : 1,
  localparam int unsigned MEM_DEPTH = NUM_QUEUES * LOCAL_SLOTS * DESC_WORDS,
  localparam int unsigned MEM_AW    = $clog2(MEM_DEPTH),
  localparam int unsigned SUM_W     = TB_LEN_W + $clog2(MAX_TBS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   baseWe,
  input  logic [QUEUE_W-1:0]     baseQueue,
  input  logic [RING_BASE_W-1:0] baseAddrHi,
  input  logic                   memWe,
  input  logic [MEM_AW-1:0]      memAddr,
  input  logic [31:0]            memData,
  input  logic [QUEUE_W-1:0]     startQueue,
  input  logic [RING_SLOT_W-1:0] startSlot,
  input  walkCtl_t               ctl,
  output logic [COUNT_W-1:0]     rawCount,
  output logic [PHYS_ADDR_W-1:0] entryAddr,
  output logic [TB_LEN_W-1:0]    entryLen,
  output logic                   lastEntry,
  output logic [SUM_W-1:0]       sumWithEntry,
  output logic [PHYS_ADDR_W-1:0] descAddr
);
  logic [31:0]            descMem [MEM_DEPTH];
  logic [RING_BASE_W-1:0] ringBase [NUM_QUEUES];
  logic [QUEUE_W-1:0]     selQueue;
  logic [RING_SLOT_W-1:0] selSlot;
  logic [COUNT_W-1:0]     cntR;
  logic [COUNT_W-1:0]     idxR;
  logic [SUM_W-1:0]       sumR;
  logic [WORD_IDX_W-1:0]  pairBase;
  logic [WORD_IDX_W-1:0]  wordA;
  logic [WORD_IDX_W-1:0]  wordB;
  logic [MEM_AW-1:0]      descBase;
  logic [31:0]            rdA;
  logic [31:0]            rdB;
  logic [31:0]            rdHead;

  always_ff @(posedge clk) begin
    if (memWe) descMem[memAddr] <= memData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < int'(NUM_QUEUES); q++) ringBase[q] <= '0;
    end else if (baseWe) begin
      for (int q = 0; q < int'(NUM_QUEUES); q++)
        if (baseQueue == QUEUE_W'(q)) ringBase[q] <= baseAddrHi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQueue <= '0;
      selSlot  <= '0;
      cntR     <= '0;
      idxR     <= '0;
      sumR     <= '0;
    end else begin
      if (ctl.latchSel) begin
        selQueue <= startQueue;
        selSlot  <= startSlot;
      end
      if (ctl.loadCount) cntR <= rawCount;
      if (ctl.clrWalk) begin
        idxR <= '0;
        sumR <= '0;
      end else begin
        if (ctl.stepWalk) idxR <= idxR + COUNT_W'(1);
        if (ctl.addLen)   sumR <= sumWithEntry;
      end
    end
  end

  // three words hold two packed entries
  always_comb begin
    pairBase = WORD_IDX_W'(1 + 3 * int'(idxR >> 1));
    wordA    = pairBase + WORD_IDX_W'(idxR[0]);
    wordB    = wordA + WORD_IDX_W'(1);
    descBase = MEM_AW'((int'(selQueue) * int'(LOCAL_SLOTS)
                        + int'(selSlot[LSLOT_W-1:0])) * int'(DESC_WORDS));
    rdA      = descMem[descBase + MEM_AW'(wordA)];
    rdB      = descMem[descBase + MEM_AW'(wordB)];
    rdHead   = descMem[descBase];
    rawCount = rdHead[COUNT_LSB +: COUNT_W];
  end

  tfd_entry_unpack u_unpack (
    .oddEntry (idxR[0]),
    .wordA    (rdA),
    .wordB    (rdB),
    .entryAddr(entryAddr),
    .entryLen (entryLen)
  );

  assign sumWithEntry = sumR + SUM_W'(entryLen);
  assign lastEntry    = (idxR == cntR - COUNT_W'(1));
  assign descAddr     = (PHYS_ADDR_W'(ringBase[selQueue]) << BASE_SHIFT)
                      + (PHYS_ADDR_W'(selSlot) << SLOT_SHIFT);
endmodule

// File: rtl/tfd_gather_ctrl.sv
module tfd_gather_ctrl
  import tfd_gather_pkg::*;
#(
  parameter int unsigned MAX_TBS       = 20,
  parameter int unsigned MAX_TB_LEN    = 4092,
  parameter int unsigned MAX_FRAME_LEN = 8192,
  parameter int unsigned SUM_W         = 17
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                reqReady,
  input  logic [COUNT_W-1:0]  rawCount,
  input  logic [TB_LEN_W-1:0] entryLen,
  input  logic                lastEntry,
  input  logic [SUM_W-1:0]    sumWithEntry,
  output walkCtl_t            ctl,
  output logic                busy,
  output logic                reqValid,
  output logic                done,
  output logic                err
);
  walkState_t state;
  walkState_t nextState;
  logic       setErr;
  logic       setDone;

  always_comb begin
    ctl       = '0;
    nextState = state;
    setErr    = 1'b0;
    setDone   = 1'b0;
    reqValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.latchSel = 1'b1;
          nextState    = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (rawCount == '0 || 32'(rawCount) > MAX_TBS) begin
          setErr    = 1'b1;
          setDone   = 1'b1;
          nextState = ST_IDLE;
        end else begin
          ctl.loadCount = 1'b1;
          ctl.clrWalk   = 1'b1;
          nextState     = ST_SUM;
        end
      end
      ST_SUM: begin
        if (32'(entryLen) > MAX_TB_LEN || 32'(sumWithEntry) > MAX_FRAME_LEN) begin
          setErr    = 1'b1;
          setDone   = 1'b1;
          nextState = ST_IDLE;
        end else if (lastEntry) begin
          ctl.clrWalk = 1'b1;
          nextState   = ST_ISSUE;
        end else begin
          ctl.addLen   = 1'b1;
          ctl.stepWalk = 1'b1;
        end
      end
      ST_ISSUE: begin
        reqValid = 1'b1;
        if (reqReady) begin
          if (lastEntry) begin
            setDone   = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctl.stepWalk = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= nextState;
      done  <= setDone;
      if (ctl.latchSel)  err <= 1'b0;
      else if (setErr)   err <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/tfd_gather_engine.sv
module tfd_gather_engine
  import tfd_gather_pkg::*;
#(
  parameter int unsigned NUM_QUEUES    = 2,
  parameter int unsigned LOCAL_SLOTS   = 4,
  parameter int unsigned MAX_TBS       = 20,
  parameter int unsigned MAX_TB_LEN    = 4092,
  parameter int unsigned MAX_FRAME_LEN = 8192,
  localparam int unsigned QUEUE_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int unsigned MEM_AW  = $clog2(NUM_QUEUES * LOCAL_SLOTS * DESC_WORDS),
  localparam int unsigned SUM_W   = TB_LEN_W + $clog2(MAX_TBS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   baseWe,
  input  logic [QUEUE_W-1:0]     baseQueue,
  input  logic [RING_BASE_W-1:0] baseAddrHi,
  input  logic                   memWe,
  input  logic [MEM_AW-1:0]      memAddr,
  input  logic [31:0]            memData,
  input  logic                   start,
  input  logic [QUEUE_W-1:0]     startQueue,
  input  logic [RING_SLOT_W-1:0] startSlot,
  output logic                   busy,
  output logic [PHYS_ADDR_W-1:0] descAddr,
  output logic                   reqValid,
  input  logic                   reqReady,
  output logic [PHYS_ADDR_W-1:0] reqAddr,
  output logic [TB_LEN_W-1:0]    reqLen,
  output logic                   done,
  output logic                   err
);
  walkCtl_t           ctl;
  logic [COUNT_W-1:0] rawCount;
  logic               lastEntry;
  logic [SUM_W-1:0]   sumWithEntry;

  tfd_gather_dpath #(
    .NUM_QUEUES (NUM_QUEUES),
    .LOCAL_SLOTS(LOCAL_SLOTS),
    .MAX_TBS    (MAX_TBS)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .baseWe      (baseWe),
    .baseQueue   (baseQueue),
    .baseAddrHi  (baseAddrHi),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memData     (memData),
    .startQueue  (startQueue),
    .startSlot   (startSlot),
    .ctl         (ctl),
    .rawCount    (rawCount),
    .entryAddr   (reqAddr),
    .entryLen    (reqLen),
    .lastEntry   (lastEntry),
    .sumWithEntry(sumWithEntry),
    .descAddr    (descAddr)
  );

  tfd_gather_ctrl #(
    .MAX_TBS      (MAX_TBS),
    .MAX_TB_LEN   (MAX_TB_LEN),
    .MAX_FRAME_LEN(MAX_FRAME_LEN),
    .SUM_W        (SUM_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .reqReady    (reqReady),
    .rawCount    (rawCount),
    .entryLen    (reqLen),
    .lastEntry   (lastEntry),
    .sumWithEntry(sumWithEntry),
    .ctl         (ctl),
    .busy        (busy),
    .reqValid    (reqValid),
    .done        (done),
    .err         (err)
  );
endmodule

// File: rtl/tfd_gather_checker.sv
module tfd_gather_checker #(
  parameter int unsigned LEN_CAP = 4092
) (
  input logic        clk,
  input logic        rstN,
  input logic        baseWe,
  input logic        busy,
  input logic [35:0] descAddr,
  input logic        reqValid,
  input logic        reqReady,
  input logic [35:0] reqAddr,
  input logic [11:0] reqLen,
  input logic        done,
  input logic        err
);
  // R4
  req_in_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqLen));

  // R7
  len_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> 32'(reqLen) <= LEN_CAP);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !reqValid);

  // R6
  err_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !reqValid);

  // R10
  desc_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && !$past(baseWe) |-> $stable(descAddr));
endmodule

bind tfd_gather_engine tfd_gather_checker u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .baseWe  (baseWe),
  .busy    (busy),
  .descAddr(descAddr),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqAddr (reqAddr),
  .reqLen  (reqLen),
  .done    (done),
  .err     (err)
);

// File: tb/tfd_gather_engine_bench.sv
`timescale 1ns/1ps
module tfd_gather_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWe = 1'b0;
  logic [0:0]  baseQueue = '0;
  logic [27:0] baseAddrHi = '0;
  logic        memWe = 1'b0;
  logic [7:0]  memAddr = '0;
  logic [31:0] memData = '0;
  logic        start = 1'b0;
  logic [0:0]  startQueue = '0;
  logic [7:0]  startSlot = '0;
  logic        busy;
  logic [35:0] descAddr;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [35:0] reqAddr;
  logic [11:0] reqLen;
  logic        done;
  logic        err;

  always #2.5 clk = ~clk;

  tfd_gather_engine u_tfd_gather_engine (
    .clk(clk), .rstN(rstN), .baseWe(baseWe), .baseQueue(baseQueue),
    .baseAddrHi(baseAddrHi), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .start(start), .startQueue(startQueue), .startSlot(startSlot), .busy(busy),
    .descAddr(descAddr), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .done(done), .err(err)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0]  dB [128];
  logic [31:0] eLo [20];
  logic [3:0]  eHi [20];
  logic [11:0] eLen [20];
  logic [27:0] baseVal [2];
  logic [35:0] gAddr [64];
  logic [11:0] gLen [64];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // R3 layout: junk in reserved bytes and tail; entry i at byte 4+6i
  task automatic clearDesc();
    for (int b = 0; b < 128; b++) dB[b] = 8'(8'hA5 ^ b);
  endtask

  task automatic setCount(input int n, input logic [2:0] junk);
    dB[3] = {junk, 5'(n)};
  endtask

  task automatic setEntry(input int i, input logic [31:0] lo, input logic [3:0] hi,
                          input logic [11:0] len);
    eLo[i] = lo; eHi[i] = hi; eLen[i] = len;
    dB[4+6*i]   = lo[7:0];
    dB[4+6*i+1] = lo[15:8];
    dB[4+6*i+2] = lo[23:16];
    dB[4+6*i+3] = lo[31:24];
    dB[4+6*i+4] = {len[3:0], hi};
    dB[4+6*i+5] = len[11:4];
  endtask

  task automatic writeDesc(input int q, input int ls);
    for (int w = 0; w < 32; w++) begin
      @(negedge clk);
      memWe   = 1'b1;
      memAddr = 8'((q * 4 + ls) * 32 + w);
      memData = {dB[4*w+3], dB[4*w+2], dB[4*w+1], dB[4*w]};
    end
    @(negedge clk);
    memWe = 1'b0;
  endtask

  task automatic writeBase(input int q, input logic [27:0] v);
    @(negedge clk);
    baseWe = 1'b1; baseQueue = 1'(q); baseAddrHi = v;
    baseVal[q] = v;
    @(negedge clk);
    baseWe = 1'b0;
  endtask

  function automatic bit readyAt(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) != 1;
      default: return ((cyc * 7) % 5) < 2;
    endcase
  endfunction

  task automatic runWalk(input int q, input int slot, input bit expErr, input int expN,
                         input int mode, input bit pokeStart, input string tag);
    int gN = 0;
    int cyc = 0;
    bit doneSeen = 0;
    bit holdPend = 0;
    logic [35:0] holdAddr = '0;
    logic [11:0] holdLen = '0;
    logic [35:0] expDesc;
    @(negedge clk);
    start = 1'b1; startQueue = 1'(q); startSlot = 8'(slot);
    @(negedge clk);
    start = 1'b0;
    expDesc = ({8'h00, baseVal[q]} << 8) + 36'(slot) * 36'd128;
    check(busy == 1'b1, "R2", {tag, " busy after start"}, longint'(busy), 1);
    check(descAddr == expDesc, "R2", {tag, " descAddr"}, longint'(descAddr), longint'(expDesc));
    while (!doneSeen && cyc < 3000) begin
      if (done) doneSeen = 1'b1;
      else begin
        if (holdPend)
          check(reqValid && reqAddr == holdAddr && reqLen == holdLen, "R5",
                {tag, " held request"}, longint'(reqAddr), longint'(holdAddr));
        reqReady = readyAt(mode, cyc);
        if (pokeStart && cyc == 2) begin
          start = 1'b1; startQueue = 1'(q ^ 1); startSlot = 8'(slot + 1);
        end else start = 1'b0;
        holdPend = reqValid && !reqReady;
        holdAddr = reqAddr; holdLen = reqLen;
        if (reqValid && reqReady && gN < 64) begin
          gAddr[gN] = reqAddr; gLen[gN] = reqLen;
          gN++;
        end
        if (pokeStart && cyc == 6)
          check(descAddr == expDesc, "R10", {tag, " descAddr after stray start"},
                longint'(descAddr), longint'(expDesc));
        @(negedge clk);
        cyc++;
      end
    end
    reqReady = 1'b0;
    start = 1'b0;
    check(doneSeen, "R9", {tag, " done seen"}, longint'(doneSeen), 1);
    check(err == expErr, expErr ? "R6" : "R4", {tag, " err at done"}, longint'(err), longint'(expErr));
    check(gN == expN, expErr ? "R8" : "R4", {tag, " request count"}, gN, expN);
    for (int i = 0; i < expN && i < gN; i++) begin
      check(gAddr[i] == {eHi[i], eLo[i]}, "R3", {tag, $sformatf(" addr of entry %0d", i)},
            longint'(gAddr[i]), longint'({eHi[i], eLo[i]}));
      check(gLen[i] == eLen[i], "R4", {tag, $sformatf(" len of entry %0d", i)},
            longint'(gLen[i]), longint'(eLen[i]));
    end
    @(negedge clk);
    check(done == 1'b0, "R9", {tag, " done one cycle"}, longint'(done), 0);
    check(err == expErr, "R9", {tag, " err held"}, longint'(err), longint'(expErr));
    check(busy == 1'b0, "R10", {tag, " idle after walk"}, longint'(busy), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!busy && !reqValid && !done && !err, "R1", "outputs in reset",
          longint'({busy, reqValid, done, err}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !reqValid && !done && !err, "R1", "outputs after reset",
          longint'({busy, reqValid, done, err}), 0);
    baseVal[0] = '0; baseVal[1] = '0;
    clearDesc(); setCount(1, 3'b000);
    setEntry(0, 32'h0000_1000, 4'h0, 12'd64);
    writeDesc(0, 2);
    // R1 base registers start at zero: descAddr is just slot*128
    runWalk(0, 2, 1'b0, 1, 0, 1'b0, "R1 zero base");

    writeBase(0, 28'h123_4567);
    writeBase(1, 28'hABC_DEF0);

    // R6 / R4 / R3 sweep over count field with junk in reserved bits 7:5
    for (int n = 0; n <= 23; n++) begin
      int cnt = (n == 23) ? 31 : n;
      bit bad = (cnt == 0) || (cnt > 20);
      clearDesc();
      setCount(cnt, 3'(n + 5));
      for (int i = 0; i < 20; i++)
        setEntry(i, (32'h8000_0001 ^ (32'(i) * 32'h0101_0103)) + 32'(cnt),
                 4'(i + cnt), 12'(8 * (i + 1) + cnt));
      writeDesc(0, cnt % 4);
      runWalk(0, (cnt % 4) + 4 * cnt, bad, bad ? 0 : cnt, n % 3, 1'b0,
              $sformatf("R6 count %0d", cnt));
    end

    // R8 total exactly 8192 accepted, queue 1 at slot 255 (local 3)
    clearDesc(); setCount(3, 3'b111);
    setEntry(0, 32'hDEAD_BEE0, 4'hF, 12'd4092);
    setEntry(1, 32'h0000_0004, 4'h1, 12'd4092);
    setEntry(2, 32'hFFFF_FFF8, 4'h8, 12'd8);
    writeDesc(1, 3);
    runWalk(1, 255, 1'b0, 3, 1, 1'b0, "R8 sum 8192");
    // R8 total 8193 rejected
    setEntry(2, 32'hFFFF_FFF8, 4'h8, 12'd9);
    writeDesc(1, 3);
    runWalk(1, 255, 1'b1, 0, 0, 1'b0, "R8 sum 8193");

    // R7 single length 4093 rejected even though frame total is small
    clearDesc(); setCount(3, 3'b000);
    setEntry(0, 32'h0000_0100, 4'h2, 12'd16);
    setEntry(1, 32'h0000_0200, 4'h3, 12'd4093);
    setEntry(2, 32'h0000_0300, 4'h4, 12'd16);
    writeDesc(1, 1);
    runWalk(1, 9, 1'b1, 0, 0, 1'b0, "R7 len 4093");
    setEntry(1, 32'h0000_0200, 4'h3, 12'd4092);
    writeDesc(1, 1);
    runWalk(1, 9, 1'b0, 3, 2, 1'b0, "R7 len 4092");

    // R10 stray start mid-walk with backpressure; other queue holds a short desc
    clearDesc(); setCount(1, 3'b000);
    setEntry(0, 32'h5555_0000, 4'h5, 12'd4);
    writeDesc(1, 2);
    clearDesc(); setCount(6, 3'b010);
    for (int i = 0; i < 6; i++)
      setEntry(i, 32'h1234_0000 + 32'(i * 40), 4'(9 - i), 12'(100 + i));
    writeDesc(0, 1);
    runWalk(0, 1, 1'b0, 6, 2, 1'b1, "R10 stray start");
    // R5 long stalls with queue 0 after queue 1 base still intact
    runWalk(0, 1, 1'b0, 6, 1, 1'b0, "R5 stall pattern");

    finishRun();
  end
endmodule